// File: doc/BRIEF.md
# Two-Level Priority Flag Scanner

This block holds a two-dimensional array of road flags and reports the address of every set flag, one per accepted cycle. Each column has its own binary priority tree over its rows. A second binary tree over the columns picks the column to serve. The nodes of both trees build the winning address as the selection moves toward the root, so the logic depth grows as the base-2 logarithm of the row count plus that of the column count.

A producer loads a complete flag array with a one-cycle strobe. A load is taken only while the scanner is empty. The consumer takes addresses with a valid/ready handshake. When an address is accepted, its flag is cleared. On the next cycle the trees present the next set flag. When no flags remain, the block asserts empty and can take the next array.

Top module: `road_flag_scanner`

## Requirements
- R1: After reset, `empty` is 1 and `valid` is 0.
- R2: The flag at column c, row r sits at bit index c*ROWS + r of `flags_in`. While `valid` is high, `addr` is {column, row}. With the default 16x16 array, the column is in bits [7:4] and the row is in bits [3:0], so `addr` equals the bit index. Only positions whose flag is set are reported.
- R3: Among the remaining flags, the lowest column wins. Within that column, the lowest row wins.
- R4: A cycle with `valid` and `ready` both high clears the reported flag. The next set flag appears on the following cycle. Every loaded flag is reported exactly once, in ascending address order.
- R5: While `ready` is low, `valid` and `addr` hold their values.
- R6: `load` is accepted only while `empty` is high. A `load` while flags remain has no effect on the flags that are reported.
- R7: `empty` is high exactly when no flags remain, and `valid` is its inverse. Loading an all-zero array leaves `empty` high.
- R8: An accepted load becomes visible at the outputs on the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Strobe that captures `flags_in` when empty |
| flags_in | input | COLS*ROWS | Flag array; bit c*ROWS+r is column c, row r |
| ready | input | 1 | Consumer accepts the presented address |
| valid | output | 1 | An address is presented |
| addr | output | log2(COLS)+log2(ROWS) | Presented address, {column, row} |
| empty | output | 1 | No flags remain |

## Verification
The flag register is the only storage, and both trees are combinational behind it. Every result is therefore due exactly one clock edge after its cause:
- a load strobe shows its first address on the next cycle;
- an accepted address is replaced by the next one on the next cycle;
- a refused load shows its lack of effect on the next cycle.

The bench drives inputs on the falling edge and samples the outputs on the following falling edge, one rising edge later. The expected address sequence is built by scanning the bench's own copy of the loaded array in ascending index order.

// File: rtl/road_flag_scanner.sv
module road_flag_scanner #(
  parameter int ROWS = 16,
  parameter int COLS = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   load,
  input  logic [COLS*ROWS-1:0]                   flags_in,
  input  logic                                   ready,
  output logic                                   valid,
  output logic [$clog2(COLS)+$clog2(ROWS)-1:0]   addr,
  output logic                                   empty
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam int NF = COLS * ROWS;

  logic [NF-1:0] flags;
  logic [COLS-1:0] col_hit;
  logic [RW-1:0] col_row [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar l = 0; l <= RW; l++) begin : lv
      localparam int N = ROWS >> l;
      logic [N-1:0] h;
      logic [RW-1:0] ix [N];
      if (l == 0) begin : g_leaf
        assign h = flags[c*ROWS +: ROWS];
        for (genvar n = 0; n < N; n++) begin : g_z
          assign ix[n] = '0;
        end
      end else begin : g_node
        for (genvar n = 0; n < N; n++) begin : g_n
          assign h[n]  = lv[l-1].h[2*n] | lv[l-1].h[2*n+1];
          assign ix[n] = lv[l-1].h[2*n] ? lv[l-1].ix[2*n]
                                        : (lv[l-1].ix[2*n+1] | (RW'(1) << (l-1)));
        end
      end
    end
    assign col_hit[c] = lv[RW].h[0];
    assign col_row[c] = lv[RW].ix[0];
  end

  for (genvar l = 0; l <= CW; l++) begin : g_top
    localparam int N = COLS >> l;
    logic [N-1:0] h;
    logic [CW-1:0] cx [N];
    logic [RW-1:0] rx [N];
    if (l == 0) begin : g_leaf
      assign h = col_hit;
      for (genvar n = 0; n < N; n++) begin : g_z
        assign cx[n] = '0;
        assign rx[n] = col_row[n];
      end
    end else begin : g_node
      for (genvar n = 0; n < N; n++) begin : g_n
        assign h[n]  = g_top[l-1].h[2*n] | g_top[l-1].h[2*n+1];
        assign cx[n] = g_top[l-1].h[2*n] ? g_top[l-1].cx[2*n]
                                         : (g_top[l-1].cx[2*n+1] | (CW'(1) << (l-1)));
        assign rx[n] = g_top[l-1].h[2*n] ? g_top[l-1].rx[2*n] : g_top[l-1].rx[2*n+1];
      end
    end
  end

  assign valid = g_top[CW].h[0];
  assign addr  = {g_top[CW].cx[0], g_top[CW].rx[0]};
  assign empty = ~valid;

  always_ff @(posedge clk) begin
    if (!rst_n)                flags <= '0;
    else if (load && empty)    flags <= flags_in;
    else if (valid && ready)   flags[addr] <= 1'b0;
  end

  a_r2_reported_is_set: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> flags[addr]);
  a_r4_cleared_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> !flags[$past(addr)]);
  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> (!valid || addr > $past(addr)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(addr)));
  a_r6_busy_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !empty && !ready) |=> (flags == $past(flags)));
  a_r7_stay_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !load) |=> empty);
endmodule

// File: tb/road_flag_scanner_tb.sv
module road_flag_scanner_tb;
  localparam int NF = 256;
  logic clk = 0, rst_n = 0, load = 0, ready = 0;
  logic [NF-1:0] flags_in = '0;
  logic valid, empty;
  logic [7:0] addr;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  road_flag_scanner u_dut (.clk(clk), .rst_n(rst_n), .load(load), .flags_in(flags_in),
                           .ready(ready), .valid(valid), .addr(addr), .empty(empty));

  // Each entry: four {enable, 8-bit address} fields
  localparam logic [35:0] TBL [8] = '{
    {9'h100, 9'h000, 9'h000, 9'h000},
    {9'h1FF, 9'h000, 9'h000, 9'h000},
    {9'h150, 9'h105, 9'h155, 9'h10F},
    {9'h1F0, 9'h10F, 9'h1E7, 9'h173},
    {9'h120, 9'h121, 9'h122, 9'h123},
    {9'h1A1, 9'h1A1, 9'h11A, 9'h000},
    {9'h180, 9'h17F, 9'h181, 9'h17E},
    {9'h101, 9'h110, 9'h111, 9'h100}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [NF-1:0] v);
    flags_in = v; load = 1;
    @(negedge clk);
    load = 0;
  endtask

  task automatic drain(logic [NF-1:0] v, string req);
    ready = 1;
    for (int i = 0; i < NF; i++) begin
      if (v[i]) begin
        chk({req, " valid"}, valid, 1);
        chk({req, " addr"}, addr, i);
        @(negedge clk);
      end
    end
    chk({req, " empty after drain R7"}, empty, 1);
    chk({req, " valid after drain R7"}, valid, 0);
    ready = 0;
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NF-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 empty", empty, 1);
    chk("R1 valid", valid, 0);

    // table walk: R2 R3 R4 R8
    for (int t = 0; t < 8; t++) begin
      v = '0;
      for (int k = 0; k < 4; k++)
        if (TBL[t][k*9+8]) v[TBL[t][k*9 +: 8]] = 1'b1;
      do_load(v);
      drain(v, "R2 R3 R4 R8 table");
    end

    // R7: all-zero load keeps empty
    do_load('0);
    chk("R7 zero load empty", empty, 1);

    // R5 hold and R6 busy load
    v = '0; v[8'h35] = 1; v[8'h12] = 1;
    do_load(v);
    chk("R8 first addr", addr, 8'h12);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R5 hold addr", addr, 8'h12);
      chk("R5 hold valid", valid, 1);
    end
    begin
      logic [NF-1:0] w;
      w = '0; w[8'h01] = 1; w[8'h00] = 1;
      do_load(w);
    end
    chk("R6 busy load ignored", addr, 8'h12);
    drain(v, "R6 R4 after busy load");

    // R3 R4: full array
    do_load('1);
    drain('1, "R4 full array");

    // R3: single flag in last corner, column beats row
    v = '0; v[8'hFF] = 1;
    do_load(v);
    drain(v, "R3 corner");
    v = '0; v[8'h1F] = 1; v[8'h20] = 1;
    do_load(v);
    chk("R3 lower column wins", addr, 8'h1F);
    drain(v, "R3 column order");

    // R1 reset mid-drain
    v = '0; v[8'h44] = 1;
    do_load(v);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R1 reset clears", empty, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule